// File: doc/BRIEF.md
# Shared Multi-Tap Frequency Divider with Periodic Interrupts

This block counts ticks of one chosen source clock, fS, through a single binary chain. The chain has an 8-stage divider followed by a 7-bit prescaler, so its taps run from fS/2^1 to fS/2^15. Four consumers draw on that one chain:

- a display clock, picked by a static option;
- a tone clock for a buzzer, picked by a static option;
- a time-base interrupt, whose period is a static option;
- a real-time interrupt, whose tap is chosen at run time by a 3-bit field in a register at address 0x09, through an 8-way tap selector.

The fS source is one of three tick inputs. The first is the internal RC oscillator tick. The second is the 32768 Hz oscillator tick. The third is the instruction clock, which the block generates itself as one tick on every fourth cycle of `clk`. Each tick input is a single-cycle enable in the `clk` domain, and the oscillators themselves sit outside the block.

Each interrupt has a pending flag. The flag is set when its tap rises and is held until software clears it. A time-base subroutine call to vector 0x0C is requested only while the flag is set, the interrupt is enabled and the stack is not full. The block has no streaming data path: every pin is a plain level or a single-cycle strobe, and there is no back-pressure.

Top module: `multi_tap_div`

## Requirements
- R1: While `rst_n` is low, the chain is zero. `lcd_clk`, `bz_clk`, `tb_pend`, `rt_pend` and `call_req` are all 0.
- R2: `src_sel` chooses the fS tick: 0 takes `rc_tick`, 1 takes `rtc_tick`, and 2 or 3 take an internal tick on every fourth `clk` cycle, first after four cycles out of reset. The chain advances by exactly one on each clock edge where the chosen tick is 1. The unselected ticks have no effect.
- R3: A `lcd_sel` value v of 0..6 makes `lcd_clk` equal to bit v+1 of the chain, which is fS/2^(v+2). A value of 7 behaves as 6 (fS/2^8).
- R4: A `bz_sel` value v of 0..7 makes `bz_clk` equal to bit v+1 of the chain, which is fS/2^(v+2).
- R5: A `tb_sel` value v of 0..3 selects the fS/2^(12+v) tap (chain bit 11+v). `tb_pend` becomes 1 one clock after the chain value at which that bit rises.
- R6: A write with `wr_en`=1 and `wr_addr`=0x09 loads `wr_data[2:0]` into the real-time select, which resets to 0. Writes to any other address leave the select unchanged. A select value v picks the fS/2^(8+v) tap (chain bit 7+v).
- R7: `rt_pend` becomes 1 one clock after the chain value at which the selected real-time tap rises.
- R8: A pending flag stays 1 until its clear strobe (`tb_clr` or `rt_clr`) is seen at a clock edge. When a clear and a new time-out arrive at the same edge, the flag ends up 1.
- R9: `call_req` is 1 exactly when `tb_pend`=1, `tb_ie`=1 and `stack_full`=0, with no clock delay. `call_vec` is always 0x0C.
- R10: Changing the real-time select does not by itself raise `rt_pend`, even when the new tap is already high. The first event after the change is the next rising edge of the newly selected tap, and edges of the old tap no longer count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | fS source: 0 RC tick, 1 32768 Hz tick, 2/3 instruction tick |
| rc_tick | input | 1 | Single-cycle tick from the RC oscillator |
| rtc_tick | input | 1 | Single-cycle tick from the 32768 Hz oscillator |
| lcd_sel | input | 3 | Static display clock option |
| bz_sel | input | 3 | Static tone clock option |
| tb_sel | input | 2 | Static time-base period option |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 3 | Real-time select write data |
| tb_ie | input | 1 | Time-base interrupt enable |
| stack_full | input | 1 | Call stack has no free entry |
| tb_clr | input | 1 | Clear strobe for the time-base pending flag |
| rt_clr | input | 1 | Clear strobe for the real-time pending flag |
| lcd_clk | output | 1 | Display clock tap |
| bz_clk | output | 1 | Tone clock tap |
| tb_pend | output | 1 | Time-base pending flag |
| rt_pend | output | 1 | Real-time pending flag |
| call_req | output | 1 | Time-base subroutine call request |
| call_vec | output | 8 | Call target vector |

## Verification
A chain that skips or repeats a count shows up within one tick as a wrong phase on `lcd_clk` or `bz_clk` at their fastest settings. A fault in a high bit shows up only when a slow tap reaches its expected edge, so the bench compares both clocks against a tick count it keeps itself, at many points across the run. A wrong select decode or a stale edge history shows up as `rt_pend` rising one clock too early, on the old tap, or right after a select write. Because of this, the bench looks at the flag on the exact cycles before and after each expected edge. A pending flag that fails to hold or clear becomes visible at the next clock.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

  // fS source encoding
  typedef enum logic [1:0] {
    SRC_RC        = 2'd0,
    SRC_RTC       = 2'd1,
    SRC_INSTR     = 2'd2,
    SRC_INSTR_ALT = 2'd3
  } src_e;

  localparam int DIV_STAGES_DEF = 8;
  localparam int PRESC_BITS_DEF = 7;
  localparam int INSTR_DIV_DEF  = 4;

  // Tap index convention: tap[j] carries fS/2^(j+2).
  localparam int TAP_BASE_EXP = 2;

  function automatic int tap_idx(input int exponent);
    return exponent - TAP_BASE_EXP;
  endfunction

endpackage

// File: rtl/mtd_src.sv
module mtd_src
  import mtd_pkg::*;
#(
  parameter int INSTR_DIV = INSTR_DIV_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       rc_tick,
  input  logic       rtc_tick,
  output logic       fs_tick
);
  localparam int DW = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(INSTR_DIV - 1);

  logic [DW-1:0] phase_q;
  logic          instr_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_q <= '0;
    else if (instr_tick)   phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end

  assign instr_tick = (phase_q == LAST);

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_RC:        fs_tick = rc_tick;
      SRC_RTC:       fs_tick = rtc_tick;
      SRC_INSTR,
      SRC_INSTR_ALT: fs_tick = instr_tick;
      default:       fs_tick = 1'b0;
    endcase
  end

  // R2
  instr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_tick |=> !instr_tick);

endmodule

// File: rtl/mtd_chain.sv
module mtd_chain
  import mtd_pkg::*;
#(
  parameter int DIV_STAGES = DIV_STAGES_DEF,
  parameter int PRESC_BITS = PRESC_BITS_DEF,
  localparam int CNT_W = DIV_STAGES + PRESC_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_tick,
  output logic [CNT_W-2:0] taps
);
  logic [DIV_STAGES-1:0] div_q;
  logic [PRESC_BITS-1:0] pre_q;
  logic                  div_wrap;

  assign div_wrap = &div_q;

  // Divider stage: low-order bits, counts every fS tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (fs_tick) div_q <= div_q + 1'b1;
  end

  // Prescaler: advances when the divider wraps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pre_q <= '0;
    else if (fs_tick && div_wrap) pre_q <= pre_q + 1'b1;
  end

  logic [CNT_W-1:0] full;
  assign full = {pre_q, div_q};
  assign taps = full[CNT_W-1:1];

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_tick |=> full == $past(full) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_tick |=> $stable(full));

endmodule

// File: rtl/mtd_tap_sel.sv
module mtd_tap_sel #(
  parameter int N     = 7,
  parameter int SEL_W = 3
) (
  input  logic [N-1:0]     taps,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_o
);
  // Out-of-range select values clamp to the slowest candidate.
  always_comb begin
    tap_o = taps[N-1];
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) tap_o = taps[i];
    end
  end

endmodule

// File: rtl/mtd_tap_evt.sv
module mtd_tap_evt #(
  parameter int N     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     taps,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic             pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic         hit;
  logic         pend_q;

  // History of every candidate, so a select change never fakes an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= taps;
  end

  assign rise = taps & ~prev_q;

  always_comb begin
    hit = rise[N-1];
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) hit = rise[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign pend = pend_q;

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clr |=> pend_q);
  // R8
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hit |=> !pend_q);
  // R7
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(hit));

endmodule

// File: rtl/multi_tap_div.sv
module multi_tap_div
  import mtd_pkg::*;
#(
  parameter int          DIV_STAGES = DIV_STAGES_DEF,
  parameter int          PRESC_BITS = PRESC_BITS_DEF,
  parameter int          INSTR_DIV  = INSTR_DIV_DEF,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  RT_ADDR    = 8'h09,
  parameter logic [7:0]  TB_VECTOR  = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic              rc_tick,
  input  logic              rtc_tick,
  input  logic [2:0]        lcd_sel,
  input  logic [2:0]        bz_sel,
  input  logic [1:0]        tb_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [2:0]        wr_data,
  input  logic              tb_ie,
  input  logic              stack_full,
  input  logic              tb_clr,
  input  logic              rt_clr,
  output logic              lcd_clk,
  output logic              bz_clk,
  output logic              tb_pend,
  output logic              rt_pend,
  output logic              call_req,
  output logic [7:0]        call_vec
);
  localparam int CNT_W = DIV_STAGES + PRESC_BITS;
  localparam int TAP_W = CNT_W - 1;

  // Tap windows (exponent ranges) for each consumer
  localparam int LCD_LO = 2,  LCD_N = 7;
  localparam int BZ_LO  = 2,  BZ_N  = 8;
  localparam int TB_LO  = 12, TB_N  = 4;
  localparam int RT_LO  = 8,  RT_N  = 8;

  logic             fs_tick;
  logic [TAP_W-1:0] taps;
  logic [2:0]       rt_sel_q;

  mtd_src #(.INSTR_DIV(INSTR_DIV)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .rc_tick  (rc_tick),
    .rtc_tick (rtc_tick),
    .fs_tick  (fs_tick)
  );

  mtd_chain #(.DIV_STAGES(DIV_STAGES), .PRESC_BITS(PRESC_BITS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs_tick (fs_tick),
    .taps    (taps)
  );

  mtd_tap_sel #(.N(LCD_N), .SEL_W(3)) u_lcd (
    .taps  (taps[tap_idx(LCD_LO) +: LCD_N]),
    .sel   (lcd_sel),
    .tap_o (lcd_clk)
  );

  mtd_tap_sel #(.N(BZ_N), .SEL_W(3)) u_bz (
    .taps  (taps[tap_idx(BZ_LO) +: BZ_N]),
    .sel   (bz_sel),
    .tap_o (bz_clk)
  );

  // Run-time real-time select register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 rt_sel_q <= '0;
    else if (wr_en && (wr_addr == RT_ADDR))     rt_sel_q <= wr_data;
  end

  mtd_tap_evt #(.N(TB_N), .SEL_W(2)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (taps[tap_idx(TB_LO) +: TB_N]),
    .sel   (tb_sel),
    .clr   (tb_clr),
    .pend  (tb_pend)
  );

  mtd_tap_evt #(.N(RT_N), .SEL_W(3)) u_rt (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (taps[tap_idx(RT_LO) +: RT_N]),
    .sel   (rt_sel_q),
    .clr   (rt_clr),
    .pend  (rt_pend)
  );

  assign call_req = tb_pend & tb_ie & ~stack_full;
  assign call_vec = TB_VECTOR;

  // R6
  rt_sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == RT_ADDR) |=> $stable(rt_sel_q));
  // R9
  call_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !call_req);

endmodule

// File: tb/multi_tap_div_tb.sv
module multi_tap_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic       rc_tick = 1'b0, rtc_tick = 1'b0;
  logic [2:0] lcd_sel = 3'd0, bz_sel = 3'd0;
  logic [1:0] tb_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'd0;
  logic [2:0] wr_data = 3'd0;
  logic       tb_ie = 1'b0, stack_full = 1'b0, tb_clr = 1'b0, rt_clr = 1'b0;
  logic       lcd_clk, bz_clk, tb_pend, rt_pend, call_req;
  logic [7:0] call_vec;

  int tests = 0, fails = 0;
  int n = 0;

  always #2.5 clk = ~clk;

  multi_tap_div u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .rc_tick(rc_tick),
    .rtc_tick(rtc_tick), .lcd_sel(lcd_sel), .bz_sel(bz_sel), .tb_sel(tb_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tb_ie(tb_ie),
    .stack_full(stack_full), .tb_clr(tb_clr), .rt_clr(rt_clr),
    .lcd_clk(lcd_clk), .bz_clk(bz_clk), .tb_pend(tb_pend), .rt_pend(rt_pend),
    .call_req(call_req), .call_vec(call_vec)
  );

  // Model tick count for the RC source path
  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else if (src_sel == 2'd0 && rc_tick) n <= n + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t n=%0d)", req, act, exp, $time, n);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_n(input int target);
    while (n != target) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [2:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int bit_of(input int val, input int exponent);
    return (val >> (exponent - 1)) & 1;
  endfunction

  // {lcd_sel, bz_sel, cycles to run}
  localparam logic [21:0] VEC [6] = '{
    {3'd0, 3'd0, 16'd5},
    {3'd2, 3'd3, 16'd37},
    {3'd6, 3'd7, 16'd300},
    {3'd7, 3'd5, 16'd129},
    {3'd4, 3'd1, 16'd1000},
    {3'd1, 3'd6, 16'd77}
  };

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 lcd_clk", lcd_clk, 0);
    check("R1 bz_clk", bz_clk, 0);
    check("R1 tb_pend", tb_pend, 0);
    check("R1 rt_pend", rt_pend, 0);
    check("R1 call_req", call_req, 0);

    // R3/R4: table walk with the RC source ticking every cycle
    rc_tick = 1'b1;
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      int ls, bs, run, le;
      ls = VEC[i][21:19]; bs = VEC[i][18:16]; run = VEC[i][15:0];
      lcd_sel = ls[2:0]; bz_sel = bs[2:0];
      repeat (run) @(negedge clk);
      le = (ls > 6) ? 8 : ls + 2;
      check("R3 lcd_clk tap", lcd_clk, bit_of(n, le));
      check("R4 bz_clk tap", bz_clk, bit_of(n, bs + 2));
    end

    // R2: 32768 Hz source, RC ticks ignored
    src_sel = 2'd1; rc_tick = 1'b1; rtc_tick = 1'b0;
    lcd_sel = 3'd0; bz_sel = 3'd1;
    do_reset();
    repeat (10) @(negedge clk);
    check("R2 rc ignored", lcd_clk, 0);
    rtc_tick = 1'b1;
    repeat (6) @(negedge clk);
    rtc_tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 rtc count bit1", lcd_clk, 1);
    check("R2 rtc count bit2", bz_clk, 1);

    // R2: instruction clock, one tick per four cycles -> 16 after 64
    src_sel = 2'd2; lcd_sel = 3'd2; bz_sel = 3'd3;
    do_reset();
    repeat (64) @(negedge clk);
    check("R2 instr bit3", lcd_clk, 0);
    check("R2 instr bit4", bz_clk, 1);

    // R5/R8/R9: time base on fS/2^13, then set-versus-clear
    src_sel = 2'd0; rc_tick = 1'b1; tb_sel = 2'd1;
    do_reset();
    wait_n(4096);
    check("R5 tb before edge", tb_pend, 0);
    @(negedge clk);
    check("R5 tb after edge", tb_pend, 1);
    tb_ie = 1'b1; stack_full = 1'b1; #1;
    check("R9 call blocked by stack", call_req, 0);
    stack_full = 1'b0; #1;
    check("R9 call raised", call_req, 1);
    check("R9 call vector", call_vec, 8'h0C);
    tb_ie = 1'b0; #1;
    check("R9 call disabled", call_req, 0);
    wait_n(4300);
    check("R8 tb holds", tb_pend, 1);
    tb_clr = 1'b1;
    @(negedge clk);
    tb_clr = 1'b0;
    check("R8 tb cleared", tb_pend, 0);
    wait_n(12288);
    tb_clr = 1'b1;
    @(negedge clk);
    tb_clr = 1'b0;
    check("R8 set beats clear", tb_pend, 1);

    // R5: fS/2^12
    tb_sel = 2'd0;
    do_reset();
    wait_n(2048);
    check("R5 tb12 before edge", tb_pend, 0);
    @(negedge clk);
    check("R5 tb12 after edge", tb_pend, 1);

    // R6/R7/R10: real-time interrupt
    do_reset();
    wait_n(128);
    check("R7 rt before edge", rt_pend, 0);
    @(negedge clk);
    check("R7 rt after edge (sel reset 0)", rt_pend, 1);
    rt_clr = 1'b1;
    @(negedge clk);
    rt_clr = 1'b0;
    check("R8 rt cleared", rt_pend, 0);
    wait_n(200);
    reg_write(8'h0A, 3'd7);
    wait_n(384);
    check("R6 other addr before edge", rt_pend, 0);
    @(negedge clk);
    check("R6 other addr ignored", rt_pend, 1);
    rt_clr = 1'b1;
    @(negedge clk);
    rt_clr = 1'b0;
    wait_n(400);
    reg_write(8'h09, 3'd1);
    wait_n(402);
    check("R10 no event on select change", rt_pend, 0);
    wait_n(641);
    check("R10 old tap ignored", rt_pend, 0);
    wait_n(768);
    check("R6 new tap before edge", rt_pend, 0);
    @(negedge clk);
    check("R10 new tap edge", rt_pend, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule